// File: doc/BRIEF.md
# Requester-ID to Stream-ID Translation Table

This block turns the 16-bit requester ID carried by an incoming PCIe transaction (bus, device, function) into the stream ID that an IOMMU and an interrupt translation unit use to pick a context. It holds a small table of entries. Each entry has a valid flag, a requester ID, a per-entry compare mask, a 6-bit stream ID and a 3-bit tag field. A lookup compares the incoming requester ID against every valid entry under that entry's own mask. The lowest-numbered entry that matches supplies the stream ID. A fixed controller ID, taken from an input pin, is placed above it.

Software reaches the table through three registers on a simple single-cycle register bus. Two data words hold the contents of one entry. An access-control word carries an entry index and a direction flag. With the flag set, a write to the access-control word copies the indexed entry into the data words so they can be read. With the flag clear, the write commits the data words into the indexed entry. An entry is removed by committing zeros to it.

Top module: `rid_sid_lut`

## Requirements
- R1: After reset every entry is invalid, all three registers read zero, and the lookup outputs `sid_valid`, `sid_hit` and `sid_out` are zero.
- R2: A write to the access-control word (offset 0x008) with bit 16 clear commits both data words into the entry whose index is in bits 4:0. Later lookups use the new contents.
- R3: A write to the access-control word with bit 16 set copies the indexed entry into data word 1 (offset 0x00C) and data word 2 (offset 0x010). The entry itself is left unchanged.
- R4: Data word 1 keeps the valid flag in bit 31, the tag in bits 10:8 and the stream ID in bits 5:0, and reads zero in every other bit. Data word 2 keeps the requester ID in bits 31:16 and the mask in bits 15:0. The access-control word reads back its index in bits 4:0 and its flag in bit 16.
- R5: A valid entry matches when (incoming ID AND mask) equals (stored ID AND mask). A mask of 0xFFFF demands equality of all 16 bits.
- R6: When several entries match, the entry with the lowest index supplies the stream ID.
- R7: When no entry matches, `sid_hit` is low and `sid_out` is zero.
- R8: `sid_valid` follows `rid_valid` one clock later. `sid_hit` can be high only while `sid_valid` is high.
- R9: On a hit, `sid_out[7:6]` carries the `ctl_id` input and `sid_out[5:0]` carries the entry's stream ID.
- R10: An entry with a clear valid flag never matches, even when its stored ID and mask would match the incoming ID. Committing zeros to an entry removes it from lookups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational, zero when not reading) |
| ctl_id | input | 2 | Fixed controller ID prepended to stream IDs |
| rid_in | input | 16 | Requester ID to translate |
| rid_valid | input | 1 | Requester ID is present this cycle |
| sid_valid | output | 1 | Lookup result present |
| sid_hit | output | 1 | Lookup found a matching entry |
| sid_out | output | 8 | Controller ID and stream ID, zero on a miss |

## Verification
The hardest case to reach from the ports is two valid entries with overlapping masks that both match one incoming ID. Only then does the lowest-index rule decide anything. The stimulus programs a wide-mask entry at a low index and an exact-match entry at a higher index on the same ID. It looks the ID up, then removes the low entry and looks it up again to show the higher entry taking over. A second awkward case is a stored entry that would match but is not valid. An entry with every field set and the valid flag clear covers this. Zero-masked entries left invalid after reset cover it as well, since they would match every ID.

// File: rtl/rsl_pkg.sv
package rsl_pkg;
   localparam int unsigned REG_DW        = 32;
   localparam logic [11:0] OFS_ACCESS    = 12'h008;
   localparam logic [11:0] OFS_WORD1     = 12'h00C;
   localparam logic [11:0] OFS_WORD2     = 12'h010;
   localparam int unsigned RDFLAG_BIT    = 16;
   localparam int unsigned VALID_BIT     = 31;
   localparam int unsigned TAG_LSB       = 8;
   localparam int unsigned RID_LSB       = 16;
   localparam int unsigned MASK_LSB      = 0;
   localparam int unsigned MAX_IDX_BITS  = 5;

   typedef enum logic [1:0] {
      SEL_NONE   = 2'd0,
      SEL_ACCESS = 2'd1,
      SEL_WORD1  = 2'd2,
      SEL_WORD2  = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/rsl_regif.sv
module rsl_regif
   import rsl_pkg::*;
#(
   parameter int unsigned N_ENTRIES = 32,
   parameter int unsigned RID_W     = 16,
   parameter int unsigned SID_W     = 6,
   parameter int unsigned TAG_W     = 3,
   parameter int unsigned ADDR_W    = 12,
   localparam int unsigned IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [REG_DW-1:0] reg_wdata,
   output logic [REG_DW-1:0] reg_rdata,
   output logic [IDX_W-1:0]  acc_idx,
   output logic              commit_req,
   output logic              load_req,
   input  logic              e_valid,
   input  logic [TAG_W-1:0]  e_tag,
   input  logic [SID_W-1:0]  e_sid,
   input  logic [RID_W-1:0]  e_rid,
   input  logic [RID_W-1:0]  e_mask,
   output logic              d_valid,
   output logic [TAG_W-1:0]  d_tag,
   output logic [SID_W-1:0]  d_sid,
   output logic [RID_W-1:0]  d_rid,
   output logic [RID_W-1:0]  d_mask
);
   reg_sel_e         wsel;
   reg_sel_e         rsel;
   logic [IDX_W-1:0] ctrl_idx;
   logic             ctrl_rdflag;

   function automatic reg_sel_e decode(input logic [ADDR_W-1:0] a);
      reg_sel_e s;
      s = SEL_NONE;
      if (a == OFS_ACCESS[ADDR_W-1:0]) s = SEL_ACCESS;
      else if (a == OFS_WORD1[ADDR_W-1:0]) s = SEL_WORD1;
      else if (a == OFS_WORD2[ADDR_W-1:0]) s = SEL_WORD2;
      return s;
   endfunction

   always_comb begin
      wsel = reg_wr ? decode(reg_addr) : SEL_NONE;
      rsel = reg_rd ? decode(reg_addr) : SEL_NONE;
   end

   assign acc_idx    = reg_wdata[IDX_W-1:0];
   assign commit_req = (wsel == SEL_ACCESS) && !reg_wdata[RDFLAG_BIT];
   assign load_req   = (wsel == SEL_ACCESS) &&  reg_wdata[RDFLAG_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_idx    <= '0;
         ctrl_rdflag <= 1'b0;
         d_valid     <= 1'b0;
         d_tag       <= '0;
         d_sid       <= '0;
         d_rid       <= '0;
         d_mask      <= '0;
      end else begin
         unique case (wsel)
            SEL_ACCESS: begin
               ctrl_idx    <= reg_wdata[IDX_W-1:0];
               ctrl_rdflag <= reg_wdata[RDFLAG_BIT];
               if (reg_wdata[RDFLAG_BIT]) begin
                  d_valid <= e_valid;
                  d_tag   <= e_tag;
                  d_sid   <= e_sid;
                  d_rid   <= e_rid;
                  d_mask  <= e_mask;
               end
            end
            SEL_WORD1: begin
               d_valid <= reg_wdata[VALID_BIT];
               d_tag   <= reg_wdata[TAG_LSB +: TAG_W];
               d_sid   <= reg_wdata[SID_W-1:0];
            end
            SEL_WORD2: begin
               d_rid  <= reg_wdata[RID_LSB +: RID_W];
               d_mask <= reg_wdata[MASK_LSB +: RID_W];
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      reg_rdata = '0;
      unique case (rsel)
         SEL_ACCESS: begin
            reg_rdata[IDX_W-1:0]  = ctrl_idx;
            reg_rdata[RDFLAG_BIT] = ctrl_rdflag;
         end
         SEL_WORD1: begin
            reg_rdata[VALID_BIT]           = d_valid;
            reg_rdata[TAG_LSB +: TAG_W]    = d_tag;
            reg_rdata[SID_W-1:0]           = d_sid;
         end
         SEL_WORD2: begin
            reg_rdata[RID_LSB +: RID_W]    = d_rid;
            reg_rdata[MASK_LSB +: RID_W]   = d_mask;
         end
         default: ;
      endcase
   end

   // R3: a load copies the selected entry's requester ID and mask into word 2
   assert_load_copies_R3: assert property (@(posedge clk) disable iff (!rst_n)
      load_req |=> (d_rid == $past(e_rid)) && (d_mask == $past(e_mask)));

   // R4: word-1 bits outside the three fields always read back as zero
   assert_word1_pad_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rsel == SEL_WORD1) |-> (reg_rdata[30:TAG_LSB+TAG_W] == '0));
endmodule

// File: rtl/rsl_table.sv
module rsl_table #(
   parameter int unsigned N_ENTRIES = 32,
   parameter int unsigned RID_W     = 16,
   parameter int unsigned SID_W     = 6,
   parameter int unsigned TAG_W     = 3,
   localparam int unsigned IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            commit_req,
   input  logic [IDX_W-1:0]                acc_idx,
   input  logic                            d_valid,
   input  logic [TAG_W-1:0]                d_tag,
   input  logic [SID_W-1:0]                d_sid,
   input  logic [RID_W-1:0]                d_rid,
   input  logic [RID_W-1:0]                d_mask,
   output logic                            e_valid,
   output logic [TAG_W-1:0]                e_tag,
   output logic [SID_W-1:0]                e_sid,
   output logic [RID_W-1:0]                e_rid,
   output logic [RID_W-1:0]                e_mask,
   input  logic [RID_W-1:0]                rid_in,
   output logic [N_ENTRIES-1:0]            match_vec,
   output logic [N_ENTRIES-1:0][SID_W-1:0] sid_vec
);
   logic [N_ENTRIES-1:0]            vld_q;
   logic [N_ENTRIES-1:0][TAG_W-1:0] tag_q;
   logic [N_ENTRIES-1:0][SID_W-1:0] sid_q;
   logic [N_ENTRIES-1:0][RID_W-1:0] rid_q;
   logic [N_ENTRIES-1:0][RID_W-1:0] msk_q;
   logic                            idx_ok;

   assign idx_ok = (32'(acc_idx) < N_ENTRIES);

   for (genvar i = 0; i < N_ENTRIES; i++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q[i] <= 1'b0;
            tag_q[i] <= '0;
            sid_q[i] <= '0;
            rid_q[i] <= '0;
            msk_q[i] <= '0;
         end else if (commit_req && (32'(acc_idx) == i)) begin
            vld_q[i] <= d_valid;
            tag_q[i] <= d_tag;
            sid_q[i] <= d_sid;
            rid_q[i] <= d_rid;
            msk_q[i] <= d_mask;
         end
      end
      assign match_vec[i] = vld_q[i] && ((rid_in & msk_q[i]) == (rid_q[i] & msk_q[i]));
      assign sid_vec[i]   = sid_q[i];
   end

   always_comb begin
      e_valid = 1'b0;
      e_tag   = '0;
      e_sid   = '0;
      e_rid   = '0;
      e_mask  = '0;
      if (idx_ok) begin
         e_valid = vld_q[acc_idx];
         e_tag   = tag_q[acc_idx];
         e_sid   = sid_q[acc_idx];
         e_rid   = rid_q[acc_idx];
         e_mask  = msk_q[acc_idx];
      end
   end

   // R2: a commit lands the data-word contents in the addressed entry
   assert_commit_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_req && idx_ok) |=> (vld_q[$past(acc_idx)] == $past(d_valid))
                                && (sid_q[$past(acc_idx)] == $past(d_sid)));

   // R10: an entry that is not valid never reports a match
   assert_invalid_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (match_vec & ~vld_q) == '0);
endmodule

// File: rtl/rsl_prio.sv
module rsl_prio #(
   parameter int unsigned N_ENTRIES = 32,
   parameter int unsigned SID_W     = 6
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [N_ENTRIES-1:0]            match_vec,
   input  logic [N_ENTRIES-1:0][SID_W-1:0] sid_vec,
   output logic                            any_hit,
   output logic [SID_W-1:0]                win_sid
);
   logic [N_ENTRIES-1:0]          grant;
   logic [N_ENTRIES:0][SID_W-1:0] acc;

   assign grant   = match_vec & (~match_vec + 1'b1);
   assign any_hit = |match_vec;
   assign acc[0]  = '0;

   for (genvar i = 0; i < N_ENTRIES; i++) begin : g_sel
      assign acc[i+1] = acc[i] | (grant[i] ? sid_vec[i] : '0);
   end

   assign win_sid = acc[N_ENTRIES];

   // R6: at most one entry is granted
   assert_single_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   // R6: a granted entry has no matching entry below it
   for (genvar i = 1; i < N_ENTRIES; i++) begin : g_chk
      assert_lowest_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
         grant[i] |-> (match_vec[i-1:0] == '0));
   end
endmodule

// File: rtl/rid_sid_lut.sv
module rid_sid_lut
   import rsl_pkg::*;
#(
   parameter int unsigned N_ENTRIES = 32,
   parameter int unsigned RID_W     = 16,
   parameter int unsigned SID_W     = 6,
   parameter int unsigned CID_W     = 2,
   parameter int unsigned TAG_W     = 3,
   parameter int unsigned ADDR_W    = 12,
   localparam int unsigned OUT_W    = CID_W + SID_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic [CID_W-1:0]  ctl_id,
   input  logic [RID_W-1:0]  rid_in,
   input  logic              rid_valid,
   output logic              sid_valid,
   output logic              sid_hit,
   output logic [OUT_W-1:0]  sid_out
);
   localparam int unsigned IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1;

   if (N_ENTRIES < 1 || N_ENTRIES > (1 << MAX_IDX_BITS))
      $error("rid_sid_lut: N_ENTRIES must be 1..32");
   if (RID_W != 16)
      $error("rid_sid_lut: data word 2 layout needs RID_W of 16");
   if (SID_W < 1 || SID_W > TAG_LSB)
      $error("rid_sid_lut: SID_W must fit below the tag field");
   if (TAG_W < 1 || TAG_LSB + TAG_W > VALID_BIT)
      $error("rid_sid_lut: TAG_W must fit below the valid bit");
   if (ADDR_W < 5)
      $error("rid_sid_lut: ADDR_W too small for the register offsets");

   logic [IDX_W-1:0]                acc_idx;
   logic                            commit_req;
   logic                            load_req;
   logic                            e_valid, d_valid;
   logic [TAG_W-1:0]                e_tag, d_tag;
   logic [SID_W-1:0]                e_sid, d_sid;
   logic [RID_W-1:0]                e_rid, d_rid, e_mask, d_mask;
   logic [N_ENTRIES-1:0]            match_vec;
   logic [N_ENTRIES-1:0][SID_W-1:0] sid_vec;
   logic                            any_hit;
   logic [SID_W-1:0]                win_sid;

   rsl_regif #(.N_ENTRIES(N_ENTRIES), .RID_W(RID_W), .SID_W(SID_W),
               .TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_regif (
      .clk, .rst_n, .reg_wr, .reg_rd, .reg_addr, .reg_wdata, .reg_rdata,
      .acc_idx, .commit_req, .load_req,
      .e_valid, .e_tag, .e_sid, .e_rid, .e_mask,
      .d_valid, .d_tag, .d_sid, .d_rid, .d_mask
   );

   rsl_table #(.N_ENTRIES(N_ENTRIES), .RID_W(RID_W), .SID_W(SID_W),
               .TAG_W(TAG_W)) u_table (
      .clk, .rst_n, .commit_req, .acc_idx,
      .d_valid, .d_tag, .d_sid, .d_rid, .d_mask,
      .e_valid, .e_tag, .e_sid, .e_rid, .e_mask,
      .rid_in, .match_vec, .sid_vec
   );

   rsl_prio #(.N_ENTRIES(N_ENTRIES), .SID_W(SID_W)) u_prio (
      .clk, .rst_n, .match_vec, .sid_vec, .any_hit, .win_sid
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sid_valid <= 1'b0;
         sid_hit   <= 1'b0;
         sid_out   <= '0;
      end else begin
         sid_valid <= rid_valid;
         sid_hit   <= rid_valid && any_hit;
         sid_out   <= (rid_valid && any_hit) ? {ctl_id, win_sid} : '0;
      end
   end

   // R8: result valid is the request valid delayed by one clock
   assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (sid_valid == $past(rid_valid)));

   // R8: a hit only accompanies a valid result
   assert_hit_qualified_R8: assert property (@(posedge clk) disable iff (!rst_n)
      sid_hit |-> sid_valid);

   // R7: a miss delivers a zero stream ID
   assert_miss_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !sid_hit |-> (sid_out == '0));

   // R9: controller ID sits above the stream ID on a hit
   assert_cid_prefix_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && sid_hit) |-> (sid_out[OUT_W-1:SID_W] == $past(ctl_id)));
endmodule

// File: tb/tb_rid_sid_lut.sv
module tb_rid_sid_lut;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [1:0]  ctl_id = 2'b10;
   logic [15:0] rid_in = '0;
   logic        rid_valid = 1'b0;
   logic        sid_valid;
   logic        sid_hit;
   logic [7:0]  sid_out;

   int n_cmp = 0;
   int n_bad = 0;
   logic done = 1'b0;

   localparam logic [11:0] A_ACC = 12'h008;
   localparam logic [11:0] A_W1  = 12'h00C;
   localparam logic [11:0] A_W2  = 12'h010;

   rid_sid_lut dut (
      .clk, .rst_n, .reg_wr, .reg_rd, .reg_addr, .reg_wdata, .reg_rdata,
      .ctl_id, .rid_in, .rid_valid, .sid_valid, .sid_hit, .sid_out
   );

   always #5 clk = ~clk;

   // vector: [31:16] requester ID, [8] expected hit, [7:0] expected sid_out
   localparam int NV = 10;
   localparam logic [31:0] VEC [NV] = '{
      32'h0100_0188,   // exact match entry 0
      32'h0101_0000,   // one bit off exact mask -> miss
      32'h0200_0191,   // entries 1 and 3 match, entry 1 wins
      32'h02FF_0191,   // upper byte mask on entry 1
      32'h0300_01BF,   // entry 5
      32'h0400_0000,   // entry 7 stored but not valid
      32'h0000_0000,   // zero-mask invalid entries must not hit
      32'h050C_01A4,   // entry 6 low nibble masked
      32'h0510_0000,   // outside entry 6 range
      32'hFFFF_0000
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1;
      #1 d = reg_rdata;
      reg_rd = 1'b0;
   endtask

   task automatic put(input int idx, input logic [31:0] w1, input logic [31:0] w2);
      wr(A_W1, w1);
      wr(A_W2, w2);
      wr(A_ACC, 32'(idx));
   endtask

   task automatic look(input logic [15:0] r, output logic [31:0] res);
      @(negedge clk);
      rid_in = r; rid_valid = 1'b1;
      @(negedge clk);
      rid_valid = 1'b0;
      res = {22'b0, sid_valid, sid_hit, sid_out};
   endtask

   initial begin
      #100000;
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      check("R1 sid_valid", {31'b0, sid_valid}, 32'd0);
      check("R1 sid_out", {24'b0, sid_out}, 32'd0);
      rst_n = 1'b1;
      rd(A_ACC, v); check("R1 access reg", v, 32'd0);
      rd(A_W1, v);  check("R1 word1", v, 32'd0);
      rd(A_W2, v);  check("R1 word2", v, 32'd0);
      look(16'h0000, v); check("R1 empty table miss", v, 32'h200);

      put(0, 32'h8000_0008, 32'h0100_FFFF);
      put(1, 32'h8000_0011, 32'h0200_FF00);
      put(3, 32'h8000_F522, 32'h0200_FFFF);
      put(5, 32'h8000_003F, 32'h0300_FFFF);
      put(6, 32'h8000_0024, 32'h0500_FFF0);
      put(7, 32'h0000_0705, 32'h0400_FFFF);

      for (int k = 0; k < NV; k++) begin
         logic [31:0] exp;
         exp = {22'b0, 1'b1, VEC[k][8], VEC[k][7:0]};
         look(VEC[k][31:16], v);
         check("R5/R6/R7/R9/R10 vector", v, exp);
      end

      // R8: no request -> no result
      @(negedge clk);
      check("R8 idle valid", {31'b0, sid_valid}, 32'd0);

      // R4: word1 padding dropped on write
      rd(A_W1, v); check("R4 word1 last written", v, 32'h0000_0705);

      // R3/R4: read back entry 3
      wr(A_ACC, 32'h0001_0003);
      rd(A_ACC, v); check("R4 access reg readback", v, 32'h0001_0003);
      rd(A_W1, v);  check("R3 entry3 word1", v, 32'h8000_0522);
      rd(A_W2, v);  check("R3 entry3 word2", v, 32'h0200_FFFF);
      look(16'h0200, v); check("R3 load leaves entry", v, 32'h391);

      // R3: unused entry reads zero
      wr(A_ACC, 32'h0001_0009);
      rd(A_W1, v); check("R3 unused word1", v, 32'd0);

      // R10: remove entry 0
      put(0, 32'h0, 32'h0);
      look(16'h0100, v); check("R10 removed entry misses", v, 32'h200);

      // R6: remove entry 1, entry 3 takes over
      put(1, 32'h0, 32'h0);
      look(16'h0200, v); check("R6 next entry wins", v, 32'h3A2);
      look(16'h02FF, v); check("R7 removed wide mask", v, 32'h200);

      // R2: rewrite entry 5 with new stream ID
      put(5, 32'h8000_0001, 32'h0300_FFFF);
      look(16'h0300, v); check("R2 recommit", v, 32'h381);

      // R9: other controller ID
      ctl_id = 2'b01;
      look(16'h0300, v); check("R9 ctl id", v, 32'h341);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule